// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block performs one multiply-accumulate step per clock for fixed-point filters, correlators and transforms. Each 16-bit input is widened to 17 bits, by sign extension or zero extension as that operand's own select asks. The two widened values are multiplied as a 17×17 two's-complement product. The product can be doubled for fractional (Q15) arithmetic. It then loads, adds into or subtracts from one of two 40-bit accumulators. Before the write, the result can be rounded to its upper bits and clamped to the 32-bit signed range.

The first multiplier operand comes either from the `op_a` port or from a loadable 16-bit holding register. Both accumulators are visible in full at all times. A read port also returns any one 16-bit slice of either accumulator: the low word, the high word, or the 8 guard bits sign-extended. A zero flag describes the last written value. Each accumulator has its own sticky overflow flag.

Top module: `fmac_unit`

## Requirements
- R1: Synchronous active-high reset clears both accumulators, the holding register, the zero flag and both overflow flags.
- R2: An operand whose signed select is 1 is sign-extended to 17 bits. An operand whose select is 0 is zero-extended. The product is the exact 17×17 two's-complement product of the extended values.
- R3: `dst_sel` 0 writes accumulator A and `dst_sel` 1 writes accumulator B. The other accumulator keeps its value.
- R4: With `en` high, `opcode` 00 loads the product, 01 adds it to the destination and 10 subtracts it from the destination. The 40-bit result wraps and is visible after the next rising edge.
- R5: `opcode` 11 with `en` high, or any cycle with `en` low, leaves both accumulators and all flags unchanged.
- R6: With `frac_mode` high, the product is shifted left by one bit before the add or subtract.
- R7: With `round_en` high, 0x8000 is added to the 40-bit sum and bits 15..0 are then cleared. Rounding is applied before saturation.
- R8: With `sat_en` high, a rounded result above 0x7FFFFFFF becomes 0x007FFFFFFF and a result below −2^31 becomes 0xFF80000000. Either clamp sets that accumulator's overflow flag, which stays set until reset. With `sat_en` low, nothing is clamped and no flag is set.
- R9: After each write, `zero_flag` is 1 exactly when the written 40-bit value is zero.
- R10: `treg_load` captures `treg_din` at the clock edge. `use_treg` replaces `op_a` with the stored value; an operation in the same cycle as a load uses the previous contents.
- R11: `rd_data` gives the accumulator chosen by `rd_acc` (0 = A, 1 = B). `rd_fld` 00 selects bits 15..0, 01 selects bits 31..16, and 1x selects bits 39..32 sign-extended to 16 bits. The port is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Perform the operation in `opcode` this cycle |
| opcode | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 none |
| dst_sel | input | 1 | Destination accumulator: 0 = A, 1 = B |
| frac_mode | input | 1 | Double the product |
| round_en | input | 1 | Round the result to bit 16 |
| sat_en | input | 1 | Clamp to 32-bit signed range |
| op_a | input | 16 | First multiplier operand |
| op_b | input | 16 | Second multiplier operand |
| a_signed | input | 1 | First operand is two's complement |
| b_signed | input | 1 | Second operand is two's complement |
| use_treg | input | 1 | Take the first operand from the holding register |
| treg_load | input | 1 | Load the holding register |
| treg_din | input | 16 | Holding register load value |
| rd_acc | input | 1 | Accumulator for the field read |
| rd_fld | input | 2 | Field for the field read |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| rd_data | output | 16 | Selected accumulator field |
| zero_flag | output | 1 | Last written value was zero |
| ovf_a | output | 1 | Sticky saturation flag of A |
| ovf_b | output | 1 | Sticky saturation flag of B |

## Verification
The assertions watch several properties on every cycle. A saturating result never leaves the 32-bit range. A rounded result that was not clamped has a clear low word. The accumulator not addressed, and everything on an idle or no-op cycle, holds still. Overflow flags never fall, the zero flag matches the value just written, and the holding register changes only when loaded. The correct product itself is shown only by the bench's scenarios: its sweeps over signedness combinations, fractional doubling and corner operands against an arithmetic model. The same applies to the exact clamp values, the old-value timing of the holding register and the field read encodings.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

    localparam int DATA_W  = 16;
    localparam int ACC_W   = 40;
    localparam int SAT_W   = 32;
    localparam int NUM_ACC = 2;

    typedef enum logic [1:0] {
        OP_MPY  = 2'b00,
        OP_MAC  = 2'b01,
        OP_MSU  = 2'b10,
        OP_NONE = 2'b11
    } mac_op_e;

    typedef struct packed {
        mac_op_e op;
        logic    frac;
        logic    rnd;
        logic    sat;
    } mac_ctl_t;

    function automatic logic op_writes(mac_op_e op);
        return op != OP_NONE;
    endfunction

    function automatic logic op_keeps_base(mac_op_e op);
        return (op == OP_MAC) || (op == OP_MSU);
    endfunction

    function automatic logic op_subtracts(mac_op_e op);
        return op == OP_MSU;
    endfunction

endpackage

// File: rtl/fmac_ext.sv
module fmac_ext #(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0] din,
    input  logic            is_signed,
    output logic [IN_W:0]   dout
);

    assign dout = {is_signed & din[IN_W-1], din};

endmodule

// File: rtl/fmac_core.sv
module fmac_core
    import fmac_pkg::*;
#(
    parameter int IN_W = DATA_W,
    parameter int AW   = ACC_W,
    parameter int SW   = SAT_W
) (
    input  logic [IN_W:0]   a_ext,
    input  logic [IN_W:0]   b_ext,
    input  logic [AW-1:0]   base_in,
    input  mac_ctl_t        ctl,
    output logic [AW-1:0]   result,
    output logic            ovf_hit
);

    localparam int EXT_W  = IN_W + 1;
    localparam int PROD_W = 2 * EXT_W;
    localparam logic [AW-1:0] RND_K    = AW'(1) << (IN_W - 1);
    localparam logic [AW-1:0] LOW_MASK = (AW'(1) << IN_W) - AW'(1);
    localparam logic [AW-1:0] POS_MAX  = (AW'(1) << (SW - 1)) - AW'(1);
    localparam logic [AW-1:0] NEG_MIN  = ~POS_MAX;

    logic signed [PROD_W-1:0] prod;
    logic signed [AW-1:0]     prod_x;
    logic        [AW-1:0]     scaled;
    logic        [AW-1:0]     base;
    logic        [AW-1:0]     sum;
    logic        [AW-1:0]     rounded;
    logic                     in_range;

    assign prod   = PROD_W'($signed(a_ext)) * PROD_W'($signed(b_ext));
    assign prod_x = AW'(prod);

    always_comb begin
        scaled   = ctl.frac ? AW'(prod_x <<< 1) : prod_x;
        base     = op_keeps_base(ctl.op) ? base_in : '0;
        sum      = op_subtracts(ctl.op) ? (base - scaled) : (base + scaled);
        rounded  = ctl.rnd ? ((sum + RND_K) & ~LOW_MASK) : sum;
        in_range = (&rounded[AW-1:SW-1]) | ~(|rounded[AW-1:SW-1]);
        ovf_hit  = ctl.sat && !in_range;
        if (ovf_hit)
            result = rounded[AW-1] ? NEG_MIN : POS_MAX;
        else
            result = rounded;
    end

    always_comb begin
        AST_SAT_RANGE: assert (!ctl.sat || (&result[AW-1:SW-1]) || !(|result[AW-1:SW-1])); // R8
        AST_ROUND_LOW: assert (!ctl.rnd || ovf_hit || (result[IN_W-1:0] == '0)); // R7
    end

endmodule

// File: rtl/fmac_acc_bank.sv
module fmac_acc_bank
    import fmac_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int NA = NUM_ACC
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [$clog2(NA)-1:0]  wr_sel,
    input  logic [AW-1:0]          wr_data,
    input  logic                   wr_ovf,
    output logic [NA-1:0][AW-1:0]  acc_q,
    output logic [NA-1:0]          ovf_q,
    output logic                   zero_q
);

    localparam int SEL_W = $clog2(NA);

    for (genvar g = 0; g < NA; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[g] <= '0;
                ovf_q[g] <= 1'b0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                acc_q[g] <= wr_data;
                if (wr_ovf)
                    ovf_q[g] <= 1'b1;
            end
        end

        AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_sel != SEL_W'(g))) |=> $stable(acc_q[g])); // R3
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
            ovf_q[g] |=> ovf_q[g]); // R8
    end

    always_ff @(posedge clk) begin
        if (rst)
            zero_q <= 1'b0;
        else if (wr_en)
            zero_q <= (wr_data == '0);
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(acc_q) && $stable(ovf_q) && $stable(zero_q))); // R5
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (zero_q == (acc_q[$past(wr_sel)] == '0))); // R9

endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
    import fmac_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ACC_W,
    parameter int SW = SAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [1:0]    opcode,
    input  logic          dst_sel,
    input  logic          frac_mode,
    input  logic          round_en,
    input  logic          sat_en,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          a_signed,
    input  logic          b_signed,
    input  logic          use_treg,
    input  logic          treg_load,
    input  logic [DW-1:0] treg_din,
    input  logic          rd_acc,
    input  logic [1:0]    rd_fld,
    output logic [AW-1:0] acc_a,
    output logic [AW-1:0] acc_b,
    output logic [DW-1:0] rd_data,
    output logic          zero_flag,
    output logic          ovf_a,
    output logic          ovf_b
);

    localparam int NA = 2;
    localparam int GW = AW - 2 * DW;

    logic [DW-1:0]         treg_q;
    logic [1:0][DW-1:0]    raw_opnd;
    logic [1:0]            raw_sgn;
    logic [1:0][DW:0]      ext_opnd;
    mac_ctl_t              ctl;
    logic [AW-1:0]         core_res;
    logic                  core_ovf;
    logic                  wr_en;
    logic [NA-1:0][AW-1:0] acc_q;
    logic [NA-1:0]         ovf_q;
    logic [AW-1:0]         rd_word;

    always_ff @(posedge clk) begin
        if (rst)
            treg_q <= '0;
        else if (treg_load)
            treg_q <= treg_din;
    end

    AST_TREG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !treg_load |=> $stable(treg_q)); // R10

    assign raw_opnd[0] = use_treg ? treg_q : op_a;
    assign raw_opnd[1] = op_b;
    assign raw_sgn[0]  = a_signed;
    assign raw_sgn[1]  = b_signed;

    for (genvar k = 0; k < 2; k++) begin : g_ext
        fmac_ext #(.IN_W(DW)) u_ext (
            .din       (raw_opnd[k]),
            .is_signed (raw_sgn[k]),
            .dout      (ext_opnd[k])
        );
    end

    assign ctl.op   = mac_op_e'(opcode);
    assign ctl.frac = frac_mode;
    assign ctl.rnd  = round_en;
    assign ctl.sat  = sat_en;
    assign wr_en    = en && op_writes(ctl.op);

    fmac_core #(.IN_W(DW), .AW(AW), .SW(SW)) u_core (
        .a_ext   (ext_opnd[0]),
        .b_ext   (ext_opnd[1]),
        .base_in (acc_q[dst_sel]),
        .ctl     (ctl),
        .result  (core_res),
        .ovf_hit (core_ovf)
    );

    fmac_acc_bank #(.AW(AW), .NA(NA)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (dst_sel),
        .wr_data (core_res),
        .wr_ovf  (core_ovf),
        .acc_q   (acc_q),
        .ovf_q   (ovf_q),
        .zero_q  (zero_flag)
    );

    assign acc_a = acc_q[0];
    assign acc_b = acc_q[1];
    assign ovf_a = ovf_q[0];
    assign ovf_b = ovf_q[1];

    always_comb begin
        rd_word = acc_q[rd_acc];
        case (rd_fld)
            2'b00:   rd_data = rd_word[DW-1:0];
            2'b01:   rd_data = rd_word[2*DW-1:DW];
            default: rd_data = {{(DW-GW){rd_word[AW-1]}}, rd_word[AW-1:2*DW]};
        endcase
    end

endmodule

// File: tb/fmac_unit_bench.sv
`timescale 1ns/1ps
module fmac_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [1:0]  opcode;
    logic        dst_sel, frac_mode, round_en, sat_en;
    logic [15:0] op_a, op_b;
    logic        a_signed, b_signed, use_treg, treg_load;
    logic [15:0] treg_din;
    logic        rd_acc;
    logic [1:0]  rd_fld;
    logic [39:0] acc_a, acc_b;
    logic [15:0] rd_data;
    logic        zero_flag, ovf_a, ovf_b;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 0;

    longint      m_acc [2];
    bit          m_zero;
    bit          m_ovf [2];
    logic [15:0] m_t;
    logic [15:0] vals [8];

    always #2.5 clk = ~clk;

    fmac_unit u_fmac_unit (
        .clk(clk), .rst(rst), .en(en), .opcode(opcode), .dst_sel(dst_sel),
        .frac_mode(frac_mode), .round_en(round_en), .sat_en(sat_en),
        .op_a(op_a), .op_b(op_b), .a_signed(a_signed), .b_signed(b_signed),
        .use_treg(use_treg), .treg_load(treg_load), .treg_din(treg_din),
        .rd_acc(rd_acc), .rd_fld(rd_fld), .acc_a(acc_a), .acc_b(acc_b),
        .rd_data(rd_data), .zero_flag(zero_flag), .ovf_a(ovf_a), .ovf_b(ovf_b)
    );

    function automatic longint sx40(longint v);
        longint w;
        w = v & 64'h0000_00FF_FFFF_FFFF;
        if (w[39]) w = w - 64'sh0000_0100_0000_0000;
        return w;
    endfunction

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, acc_a, 40'(m_acc[0]));
        chk(req, acc_b, 40'(m_acc[1]));
        chk("R9", 40'(zero_flag), 40'(m_zero));
        chk("R8", 40'(ovf_a), 40'(m_ovf[0]));
        chk("R8", 40'(ovf_b), 40'(m_ovf[1]));
    endtask

    task automatic run_op(input logic [1:0] op, input logic dst,
                          input logic [15:0] a, input logic [15:0] b,
                          input logic as_, input logic bs_,
                          input logic fr, input logic rn, input logic st,
                          input logic ut, input logic ld, input logic [15:0] ldv);
        longint ea, eb, p, base, s;
        logic [15:0] av;
        av = ut ? m_t : a;
        ea = as_ ? longint'($signed(av)) : longint'(av);
        eb = bs_ ? longint'($signed(b))  : longint'(b);
        if (op != 2'b11) begin
            p = ea * eb;
            if (fr) p = p * 2;
            base = (op == 2'b00) ? 0 : m_acc[dst];
            s = (op == 2'b10) ? sx40(base - p) : sx40(base + p);
            if (rn) begin
                s = sx40(s + 32768);
                s = s & -64'sd65536;
            end
            if (st && (s > 64'sd2147483647 || s < -64'sd2147483648)) begin
                m_ovf[dst] = 1;
                s = (s < 0) ? -64'sd2147483648 : 64'sd2147483647;
            end
            m_acc[dst] = s;
            m_zero = (s == 0);
        end
        if (ld) m_t = ldv;
        en = 1; opcode = op; dst_sel = dst; op_a = a; op_b = b;
        a_signed = as_; b_signed = bs_; frac_mode = fr; round_en = rn;
        sat_en = st; use_treg = ut; treg_load = ld; treg_din = ldv;
        @(negedge clk);
        en = 0; treg_load = 0; use_treg = 0;
    endtask

    task automatic mop(input logic [1:0] op, input logic dst,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic as_, input logic bs_,
                       input logic fr, input logic rn, input logic st);
        run_op(op, dst, a, b, as_, bs_, fr, rn, st, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic check_field(input logic acc, input logic [1:0] fld);
        logic [39:0] e;
        logic [15:0] x;
        e = 40'(m_acc[acc]);
        rd_acc = acc; rd_fld = fld;
        #1;
        case (fld)
            2'b00:   x = e[15:0];
            2'b01:   x = e[31:16];
            default: x = {{8{e[39]}}, e[39:32]};
        endcase
        chk("R11", 40'(rd_data), 40'(x));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                 16'h8000, 16'h4000, 16'h1234, 16'hFEDC};
        m_acc[0] = 0; m_acc[1] = 0; m_zero = 0; m_ovf[0] = 0; m_ovf[1] = 0; m_t = 0;
        rst = 1; en = 0; opcode = 0; dst_sel = 0; frac_mode = 0; round_en = 0;
        sat_en = 0; op_a = 0; op_b = 0; a_signed = 0; b_signed = 0;
        use_treg = 0; treg_load = 0; treg_din = 0; rd_acc = 0; rd_fld = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_all("R1");
        // R1: holding register cleared -> product with it is zero
        run_op(2'b00, 1'b0, 16'h1111, 16'h0005, 1, 1, 0, 0, 0, 1'b1, 1'b0, 16'h0);
        check_all("R1");

        // R2 / R6: multiply sweep over operands, signedness and fractional mode
        for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++)
                for (int sg = 0; sg < 4; sg++)
                    for (int fr = 0; fr < 2; fr++) begin
                        mop(2'b00, 1'((ia + ib) % 2), vals[ia], vals[ib],
                            1'(sg & 1), 1'(sg >> 1), 1'(fr), 0, 0);
                        check_all(fr != 0 ? "R6" : "R2");
                    end

        // R4 / R7: accumulate chain into A with rounding on alternate steps
        for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++) begin
                mop(2'b01, 1'b0, vals[ia], vals[ib], 1, 1, 1'(ia & 1), 1'(ib & 1), 0);
                check_all((ib & 1) != 0 ? "R7" : "R4");
            end

        // R4 / R8: subtract chain into B with saturation
        for (int ia = 0; ia < 8; ia++)
            for (int ib = 0; ib < 8; ib++) begin
                mop(2'b10, 1'b1, vals[ia], vals[ib], 1'(ib & 1), 1, 1, 0, 1);
                check_all("R8");
            end

        // R8: positive clamp on A, sticky flag
        mop(2'b00, 1'b0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 1);
        check_all("R8");
        mop(2'b01, 1'b0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 1);
        check_all("R8");
        chk("R8", acc_a, 40'h00_7FFF_FFFF);
        mop(2'b00, 1'b0, 16'h0002, 16'h0003, 1, 1, 0, 0, 1);
        check_all("R8");
        chk("R8", 40'(ovf_a), 40'd1);

        // R8: negative clamp on B
        mop(2'b00, 1'b1, 16'h8000, 16'h7FFF, 1, 1, 1, 0, 1);
        mop(2'b01, 1'b1, 16'h8000, 16'h7FFF, 1, 1, 1, 0, 1);
        check_all("R8");
        chk("R8", acc_b, 40'hFF_8000_0000);

        // R8: no saturation -> growth into guard bits, no flag on a reset model
        rst = 1; @(negedge clk); rst = 0;
        m_acc[0] = 0; m_acc[1] = 0; m_zero = 0; m_ovf[0] = 0; m_ovf[1] = 0; m_t = 0;
        for (int i = 0; i < 4; i++) begin
            mop(2'b01, 1'b0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, 0);
            check_all("R8");
        end
        chk("R8", 40'(ovf_a), 40'd0);

        // R7: rounding corners
        mop(2'b00, 1'b1, 16'h0001, 16'h8000, 0, 0, 0, 1, 0);
        check_all("R7");
        chk("R7", acc_b, 40'h00_0001_0000);
        mop(2'b00, 1'b1, 16'h0001, 16'h7FFF, 0, 0, 0, 1, 0);
        check_all("R7");
        chk("R9", 40'(zero_flag), 40'd1);
        mop(2'b00, 1'b1, 16'hFFFF, 16'h0001, 1, 1, 0, 1, 0);
        check_all("R7");

        // R3: write to B only, A keeps its guard growth
        mop(2'b01, 1'b1, 16'h0100, 16'h0100, 1, 1, 0, 0, 0);
        check_all("R3");

        // R5: opcode 11 and en low leave everything unchanged
        mop(2'b11, 1'b0, 16'h7FFF, 16'h7FFF, 1, 1, 1, 1, 1);
        check_all("R5");
        opcode = 2'b00; dst_sel = 1; op_a = 16'h1234; op_b = 16'h0FF0; en = 0; sat_en = 1;
        @(negedge clk);
        check_all("R5");

        // R9: subtract back to exact zero
        mop(2'b00, 1'b0, 16'h0123, 16'h0045, 1, 1, 0, 0, 0);
        mop(2'b10, 1'b0, 16'h0123, 16'h0045, 1, 1, 0, 0, 0);
        check_all("R9");
        chk("R9", 40'(zero_flag), 40'd1);

        // R10: load in same cycle uses old contents, then new contents
        run_op(2'b00, 1'b0, 16'h0009, 16'h0007, 1, 1, 0, 0, 0, 1'b1, 1'b1, 16'hFFFD);
        check_all("R10");
        run_op(2'b00, 1'b0, 16'h0009, 16'h0007, 1, 1, 0, 0, 0, 1'b1, 1'b0, 16'h0);
        check_all("R10");
        chk("R10", acc_a, 40'hFF_FFFF_FFEB);
        run_op(2'b00, 1'b1, 16'h0009, 16'h0007, 0, 1, 0, 0, 0, 1'b1, 1'b0, 16'h0);
        check_all("R10");

        // R11: field reads on a negative and on a guard-positive value
        mop(2'b00, 1'b0, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, 0);
        mop(2'b00, 1'b1, 16'h8000, 16'h1234, 1, 1, 0, 0, 0);
        for (int a = 0; a < 2; a++)
            for (int f = 0; f < 4; f++)
                check_field(1'(a), 2'(f));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule